// File: doc/BRIEF.md
# Banked Bit-Toggle Execution Unit

This unit carries out one instruction: invert a single bit of a byte held in data memory. It accepts a 16-bit instruction word with a valid strobe, checks the opcode, pulls out the bit index, the bank-mode bit and the 8-bit file field, and works out a 12-bit effective address. There are three ways to form that address. One uses a fixed access window split between low general-purpose bytes and the high special-function page. One puts a bank-select value in front of the file field. The third adds the file field to an index pointer when extended mode is on.

Each instruction runs in four phases: decode, read, process and write. The unit issues a read on a synchronous memory port, flips the selected bit in the returned byte, and writes the byte back to the same address. Busy covers the four phases, and a done pulse comes with the write. No flag or status state is touched. The surrounding core feeds instructions one at a time and waits for done before it issues the next.

Top module: `bit_flip_unit`

## Requirements
- R1: After synchronous reset, busy, done, mem_rd_en and mem_wr_en are all low.
- R2: An instruction is accepted only when the unit is idle, instr_valid is high and instr[15:12] equals 4'b0111. Any other word is ignored: busy stays low and no memory read or write is issued.
- R3: The fields are decoded as bit index b = instr[11:9], bank-mode bit a = instr[8] and file field f = instr[7:0]. bsr, idx_ptr and ext_en are sampled in the same cycle as the accepted instruction.
- R4: When a = 1, the effective address is {bsr[3:0], f}.
- R5: When a = 0 and indexed mode does not apply, f below 60h addresses byte f of page 0 (address 000h to 05Fh).
- R6: When a = 0 and f is 60h or above, the address is F00h + f (F60h to FFFh), whatever the value of ext_en.
- R7: When a = 0, ext_en = 1 and f is at most 5Fh, the address is (idx_ptr + f) mod 4096.
- R8: Phase timing. Busy is high in the four cycles after acceptance. mem_rd_en is high in the second of those cycles. mem_wr_en and done are high together in the fourth. The unit is idle in the cycle after that.
- R9: The written byte equals the byte read with only bit b inverted. For example, 75h with b = 4 gives 65h. The write goes to the address that was read.
- R10: instr_valid pulses that arrive while the unit is busy are ignored. Exactly one write results per accepted instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction strobe |
| instr | input | 16 | Instruction word |
| bsr | input | 4 | Bank-select value |
| idx_ptr | input | 12 | Index pointer for indexed offset mode |
| ext_en | input | 1 | Extended addressing enable |
| mem_addr | output | 12 | Data memory address |
| mem_rd_en | output | 1 | Read strobe; data returns on the next cycle |
| mem_rdata | input | 8 | Read data from memory |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | High while an instruction executes |
| done | output | 1 | One-cycle pulse with the write |

## Verification
The assertions check, on every cycle, the following properties:
- Each read is followed two cycles later by a write to the same address.
- The written byte differs from the byte just read in exactly one bit.
- A running instruction cannot restart.
- No memory strobe is issued while the unit is idle.

The bench scenarios cover the rest:
- The address arithmetic in all three modes, including the access split at 60h and wraparound of the index sum. These checks sweep every file value and every bit index.
- The rejection of wrong opcodes.
- The exact cycles of the strobes.

// File: rtl/btu_pkg.sv
package btu_pkg;
  parameter int INSTR_W = 16;
  parameter int OPC_W   = 4;
  parameter int BIT_W   = 3;
  parameter int FILE_W  = 8;
  parameter logic [OPC_W-1:0] OPC_TOGGLE = 4'b0111;

  typedef enum logic [2:0] {
    PH_IDLE, PH_Q1, PH_Q2, PH_Q3, PH_Q4
  } phase_t;

  typedef enum logic [1:0] {
    AM_LOW, AM_HIGH, AM_BANKED, AM_INDEXED
  } amode_t;

  typedef struct packed {
    logic [BIT_W-1:0]  bit_sel;
    logic              banked;
    logic [FILE_W-1:0] file;
  } fields_t;
endpackage

// File: rtl/btu_decode.sv
module btu_decode
  import btu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output logic               is_toggle,
  output fields_t            fields
);
  localparam int OPC_LSB = INSTR_W - OPC_W;

  // R2 opcode compare, R3 field extraction
  always_comb begin
    is_toggle      = (instr[INSTR_W-1:OPC_LSB] == OPC_TOGGLE);
    fields.bit_sel = instr[FILE_W+1+:BIT_W];
    fields.banked  = instr[FILE_W];
    fields.file    = instr[FILE_W-1:0];
  end
endmodule

// File: rtl/btu_addr_gen.sv
module btu_addr_gen
  import btu_pkg::*;
#(
  parameter int ADDR_W              = 12,
  parameter int BANK_W              = 4,
  parameter logic [FILE_W-1:0] SPLIT = 8'h60,
  parameter bit IDX_EN              = 1'b1
) (
  input  logic [FILE_W-1:0] file,
  input  logic              banked,
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] idx,
  input  logic              ext_en,
  output logic [ADDR_W-1:0] ea,
  output amode_t            mode
);
  localparam int PAGE_W = ADDR_W - FILE_W;
  localparam logic [PAGE_W-1:0] TOP_PAGE = {PAGE_W{1'b1}};

  logic              low_half;
  logic              idx_sel;
  logic [ADDR_W-1:0] idx_sum;

  assign low_half = (file < SPLIT);

  generate
    if (IDX_EN) begin : g_idx
      assign idx_sel = !banked && ext_en && low_half;
      assign idx_sum = idx + {{PAGE_W{1'b0}}, file};
    end else begin : g_noidx
      assign idx_sel = 1'b0;
      assign idx_sum = '0;
    end
  endgenerate

  always_comb begin
    if (banked) begin
      mode = AM_BANKED;                                 // R4
      ea   = {bank[PAGE_W-1:0], file};
    end else if (idx_sel) begin
      mode = AM_INDEXED;                                // R7
      ea   = idx_sum;
    end else if (low_half) begin
      mode = AM_LOW;                                    // R5
      ea   = {{PAGE_W{1'b0}}, file};
    end else begin
      mode = AM_HIGH;                                   // R6
      ea   = {TOP_PAGE, file};
    end
  end
endmodule

// File: rtl/btu_phase_seq.sv
module btu_phase_seq
  import btu_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  output phase_t phase,
  output logic   busy
);
  phase_t nxt;

  always_comb begin
    case (phase)
      PH_IDLE: nxt = start ? PH_Q1 : PH_IDLE;
      PH_Q1:   nxt = PH_Q2;
      PH_Q2:   nxt = PH_Q3;
      PH_Q3:   nxt = PH_Q4;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      busy  <= 1'b0;
    end else begin
      phase <= nxt;
      busy  <= (nxt != PH_IDLE);
    end
  end

  AST_Q1_TO_Q2: assert property (@(posedge clk) disable iff (rst)
    phase == PH_Q1 |=> phase == PH_Q2);                                  // R8
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && phase != PH_Q4) |=> phase != PH_IDLE && phase != PH_Q1); // R10
endmodule

// File: rtl/bit_flip_unit.sv
module bit_flip_unit
  import btu_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int BANK_W = 4,
  parameter bit IDX_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [BANK_W-1:0]  bsr,
  input  logic [ADDR_W-1:0]  idx_ptr,
  input  logic               ext_en,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_rd_en,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               mem_wr_en,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic               busy,
  output logic               done
);
  localparam int NBITS = 1 << BIT_W;

  phase_t            phase;
  logic              is_toggle;
  logic              accept;
  fields_t           dec_f;
  fields_t           cur_f;
  logic [BANK_W-1:0] cur_bank;
  logic [ADDR_W-1:0] cur_idx;
  logic              cur_ext;
  logic [ADDR_W-1:0] ea;
  amode_t            mode;
  amode_t            mode_q;
  logic [DATA_W-1:0] flip_mask;

  btu_decode u_dec (
    .instr     (instr),
    .is_toggle (is_toggle),
    .fields    (dec_f)
  );

  assign accept = instr_valid && is_toggle && (phase == PH_IDLE);

  btu_phase_seq u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (accept),
    .phase (phase),
    .busy  (busy)
  );

  btu_addr_gen #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W),
    .IDX_EN (IDX_EN)
  ) u_agen (
    .file   (cur_f.file),
    .banked (cur_f.banked),
    .bank   (cur_bank),
    .idx    (cur_idx),
    .ext_en (cur_ext),
    .ea     (ea),
    .mode   (mode)
  );

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      if (i < NBITS) begin : g_sel
        assign flip_mask[i] = (cur_f.bit_sel == i[BIT_W-1:0]);
      end else begin : g_none
        assign flip_mask[i] = 1'b0;
      end
    end
  endgenerate

  // Operand capture on acceptance (R3)
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_f    <= '0;
      cur_bank <= '0;
      cur_idx  <= '0;
      cur_ext  <= 1'b0;
    end else if (accept) begin
      cur_f    <= dec_f;
      cur_bank <= bsr;
      cur_idx  <= idx_ptr;
      cur_ext  <= ext_en;
    end
  end

  // Memory side: address and read strobe leave Q1, write leaves Q3
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_rd_en <= 1'b0;
      mem_wr_en <= 1'b0;
      mem_wdata <= '0;
      done      <= 1'b0;
      mode_q    <= AM_LOW;
    end else begin
      mem_rd_en <= (phase == PH_Q1);
      mem_wr_en <= (phase == PH_Q3);
      done      <= (phase == PH_Q3);
      if (phase == PH_Q1) begin
        mem_addr <= ea;
        mode_q   <= mode;
      end
      if (phase == PH_Q3) begin
        mem_wdata <= mem_rdata ^ flip_mask;
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_rd_en && !mem_wr_en && !done);                        // R2
  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> ##1 mem_wr_en && done);                                // R8
  AST_WR_SAME_ADDR: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> mem_addr == $past(mem_addr, 2));                       // R9
  AST_ONE_BIT_FLIP: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> $countones(mem_wdata ^ $past(mem_rdata)) == 1);        // R9
  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);                                                      // R8
  AST_BANK_ADDR: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && mode_q == AM_BANKED) |-> mem_addr[ADDR_W-1:FILE_W] == cur_bank[ADDR_W-FILE_W-1:0]); // R4
  AST_HIGH_PAGE: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && mode_q == AM_HIGH) |-> &mem_addr[ADDR_W-1:FILE_W]);   // R6
endmodule

// File: tb/bit_flip_unit_test.sv
`timescale 1ns/1ps
module bit_flip_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = '0;
  logic [3:0]  bsr = '0;
  logic [11:0] idx_ptr = '0;
  logic        ext_en = 1'b0;
  logic [11:0] mem_addr;
  logic        mem_rd_en;
  logic [7:0]  mem_rdata;
  logic        mem_wr_en;
  logic [7:0]  mem_wdata;
  logic        busy;
  logic        done;

  int tests = 0;
  int fails = 0;
  logic [7:0] mem [0:4095];
  int wr_count = 0;

  always #2.5 clk = ~clk;

  bit_flip_unit uut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .bsr(bsr), .idx_ptr(idx_ptr), .ext_en(ext_en),
    .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
    .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    if (mem_wr_en) begin
      mem[mem_addr] <= mem_wdata;
      wr_count <= wr_count + 1;
    end
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_addr(input logic [7:0] f, input logic a,
      input logic [3:0] bs, input logic [11:0] ix, input logic e);
    if (a) return {bs, f};
    if (e && f <= 8'h5F) return 12'((32'(ix) + 32'(f)) % 4096);
    if (f < 8'h60) return {4'h0, f};
    return 12'hF00 + {4'h0, f};
  endfunction

  function automatic string mode_tag(input logic [7:0] f, input logic a, input logic e);
    if (a) return "R4";
    if (e && f <= 8'h5F) return "R7";
    if (f < 8'h60) return "R5";
    return "R6";
  endfunction

  task automatic run_op(input logic [2:0] b, input logic a, input logic [7:0] f,
      input logic [3:0] bs, input logic [11:0] ix, input logic e, input logic [7:0] val);
    logic [11:0] ea;
    string tg;
    ea = exp_addr(f, a, bs, ix, e);
    tg = mode_tag(f, a, e);
    mem[ea] = val;
    @(negedge clk);
    instr = {4'b0111, b, a, f}; bsr = bs; idx_ptr = ix; ext_en = e; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0; bsr = ~bs; idx_ptr = ~ix; ext_en = ~e;  // R3 sampled only at accept
    check("R8 busy q1", busy, 1);
    check("R8 rd q1", mem_rd_en, 0);
    @(negedge clk);
    check("R8 rd q2", mem_rd_en, 1);
    check(tg, mem_addr, ea);
    @(negedge clk);
    check("R8 q3 quiet", {mem_rd_en, mem_wr_en, done}, 0);
    @(negedge clk);
    check("R8 wr/done q4", {mem_wr_en, done, busy}, 3'b111);
    check("R9 wdata", mem_wdata, val ^ (8'h1 << b));
    check(tg, mem_addr, ea);
    @(negedge clk);
    check("R8 idle", {busy, done, mem_wr_en}, 0);
    check("R9 stored", mem[ea], val ^ (8'h1 << b));
  endtask

  initial begin
    int lim = 0;
    while (lim < 150000) begin @(posedge clk); lim++; end
    fails++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int wc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset", {busy, done, mem_rd_en, mem_wr_en}, 0);

    // R9 worked example
    run_op(3'd4, 1'b1, 8'h20, 4'h1, 12'h000, 1'b0, 8'h75);
    check("R9 75h->65h", mem[12'h120], 8'h65);

    // R4 banked: every bit index with every bank
    for (int bs = 0; bs < 16; bs++)
      for (int b = 0; b < 8; b++)
        run_op(3'(b), 1'b1, 8'((bs * 29 + b * 53) & 255), 4'(bs), 12'h5A5, 1'b1,
               8'((bs * 11 + b * 37 + 5) & 255));

    // R5 / R6 access window, all file values, extended mode off
    for (int f = 0; f < 256; f++)
      run_op(3'(f % 8), 1'b0, 8'(f), 4'h7, 12'h321, 1'b0, 8'((f * 37 + 9) & 255));

    // R7 / R6 extended mode on, index near the top to exercise wraparound
    for (int f = 0; f < 256; f++)
      run_op(3'((f * 3) % 8), 1'b0, 8'(f), 4'h2, 12'hFC0, 1'b1, 8'((f * 91 + 3) & 255));
    run_op(3'd0, 1'b0, 8'h5F, 4'h0, 12'hFA1, 1'b1, 8'hFF);
    check("R7 wrap to 000", mem[12'h000], 8'hFE);

    // R2 wrong opcodes ignored
    for (int op = 0; op < 16; op++) begin
      if (op == 7) continue;
      wc = wr_count;
      @(negedge clk);
      instr = {4'(op), 12'h355}; instr_valid = 1'b1;
      @(negedge clk);
      instr_valid = 1'b0;
      repeat (5) begin
        check("R2 no busy", {busy, mem_rd_en, mem_wr_en}, 0);
        @(negedge clk);
      end
      check("R2 no write", wr_count, wc);
    end

    // R10 valid while busy ignored
    wc = wr_count;
    mem[12'h310] = 8'h00;
    mem[12'h3F0] = 8'h00;
    @(negedge clk);
    instr = {4'b0111, 3'd1, 1'b1, 8'h10}; bsr = 4'h3; instr_valid = 1'b1;
    @(negedge clk);
    instr = {4'b0111, 3'd2, 1'b1, 8'hF0};
    repeat (3) @(negedge clk);
    instr_valid = 1'b0;
    @(negedge clk);
    check("R10 idle after one op", busy, 0);
    repeat (4) @(negedge clk);
    check("R10 one write", wr_count, wc + 1);
    check("R10 first op done", mem[12'h310], 8'h02);
    check("R10 second untouched", mem[12'h3F0], 8'h00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule